// File: doc/BRIEF.md
# Dual-Host Register Access Arbiter

This block lets two independent masters share one internal register access path. One master is a parallel microprocessor port. The other is a serial control port that has already turned its shifted-in control word into an address, a data byte and a read/write flag. Each host raises a one-cycle request pulse together with its address, write data and direction. The arbiter latches the request and grants the shared path to one host at a time. It holds the access for a fixed number of cycles and then returns completion and read data to the host that was granted.

The serial host wins whenever both hosts are waiting. A microprocessor access that has already been granted runs to its end without interruption. While the microprocessor waits, it sees the stall in one of two ways, chosen by a mode input. In the wait style, a ready line is held low until its access completes. In the acknowledge style, an active-low acknowledge strobe is withheld until completion.

The serial port stays locked out of the shared path until the microprocessor has written a boot-complete bit. Until that bit is set, serial requests are answered at once with zero data and make no access.

Top module: `dual_host_arb`

## Requirements
- R1: After reset, `mp_rdy` is 1, `mp_dtack_n` is 1, `reg_en` is 0, `sp_done` is 0 and `boot_ok` is 0.
- R2: Each granted access drives `reg_en` high for exactly ACC_CYC consecutive cycles. During those cycles it presents the granted host's address, data and direction (`reg_wr`=1 for a write). On an uncontested path, completion is seen ACC_CYC+1 cycles after the edge that captures the request.
- R3: When both hosts have requests pending while the path is idle, the serial access is performed first. The microprocessor access then completes max(ACC_CYC+1, 2·ACC_CYC+2−k) cycles after its capture edge, where k is how many cycles its capture edge falls after the serial capture edge.
- R4: With `mp_mode_ack`=0 (wait style), `mp_rdy` is low from the capture edge until the completion edge. Completion is the cycle in which `mp_rdy` returns high, and `mp_dtack_n` never goes low.
- R5: With `mp_mode_ack`=1 (acknowledge style), `mp_rdy` stays high and `mp_dtack_n` is low for exactly one cycle, the completion cycle.
- R6: A microprocessor access that has been granted is never preempted. A serial request arriving k cycles later completes max(ACC_CYC+1, 2·ACC_CYC+2−k) cycles after its own capture edge.
- R7: For a read, the host's read-data output takes the value of `reg_rdata` sampled in the last access cycle. The output holds that value until the host's next read.
- R8: Before boot, a serial request makes no shared-path access. `sp_done` pulses one cycle after capture, and `sp_rdata` becomes 0.
- R9: A microprocessor write to address BOOT_ADDR with data bit 0 equal to 1 sets `boot_ok` at its completion. A write with bit 0 equal to 0 does not set it, and once set, `boot_ok` stays set until reset.
- R10: A further request pulse from a host whose previous request is still pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mp_mode_ack | input | 1 | Microprocessor handshake style: 0 wait/ready, 1 acknowledge |
| mp_req | input | 1 | Microprocessor request pulse |
| mp_wr | input | 1 | Microprocessor direction, 1 = write |
| mp_addr | input | AW | Microprocessor register address |
| mp_wdata | input | DW | Microprocessor write data |
| mp_rdy | output | 1 | Wait-style ready, low while stalled |
| mp_dtack_n | output | 1 | Acknowledge-style completion strobe, active low |
| mp_rdata | output | DW | Microprocessor read data |
| sp_req | input | 1 | Serial host request pulse |
| sp_wr | input | 1 | Serial host direction, 1 = write |
| sp_addr | input | AW | Serial host register address |
| sp_wdata | input | DW | Serial host write data |
| sp_done | output | 1 | Serial access completion pulse |
| sp_rdata | output | DW | Serial host read data |
| boot_ok | output | 1 | Boot-complete flag, enables serial access |
| reg_en | output | 1 | Shared path access active |
| reg_wr | output | 1 | Shared path write strobe |
| reg_addr | output | AW | Shared path address |
| reg_wdata | output | DW | Shared path write data |
| reg_rdata | input | DW | Read data from the register file |

## Verification
The two functions that can land on the same cycle are the serial grant and the microprocessor grant. Both contend for the path when their pending flags are set together. They are provoked by sweeping the offset between the two request pulses from 0 to ACC_CYC+1, in both handshake modes and in both arrival orders. Each run is judged by the completion cycle of each host against the arithmetic latency formulas, by which address appears first on the shared path, and by the number of ready-low or acknowledge cycles for that offset.

// File: rtl/dhra_pkg.sv
package dhra_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SP   = 2'd1,
        ST_MP   = 2'd2
    } arb_st_e;
endpackage

// File: rtl/dhra_req_latch.sv
module dhra_req_latch #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          clr_i,
    output logic          pend_o,
    output logic          wr_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o
);
    typedef struct packed {
        logic          pend;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (clr_i) begin
            lat_d.pend = 1'b0;
        end else if (req_i && !lat_q.pend) begin
            lat_d.pend  = 1'b1;
            lat_d.wr    = wr_i;
            lat_d.addr  = addr_i;
            lat_d.wdata = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign pend_o  = lat_q.pend;
    assign wr_o    = lat_q.wr;
    assign addr_o  = lat_q.addr;
    assign wdata_o = lat_q.wdata;

    // R10: a held request keeps its captured fields until cleared
    a_r10_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q.pend && !clr_i) |=> (lat_q.pend && $stable(lat_q.addr) && $stable(lat_q.wdata)));
endmodule

// File: rtl/dhra_arb_core.sv
module dhra_arb_core
    import dhra_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            DW        = 8,
    parameter int            ACC_CYC   = 3,
    parameter logic [AW-1:0] BOOT_ADDR = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sp_pend_i,
    input  logic          sp_wr_i,
    input  logic [AW-1:0] sp_addr_i,
    input  logic [DW-1:0] sp_wdata_i,
    input  logic          mp_pend_i,
    input  logic          mp_wr_i,
    input  logic [AW-1:0] mp_addr_i,
    input  logic [DW-1:0] mp_wdata_i,
    input  logic [DW-1:0] reg_rdata_i,
    output logic          reg_en_o,
    output logic          reg_wr_o,
    output logic [AW-1:0] reg_addr_o,
    output logic [DW-1:0] reg_wdata_o,
    output logic          sp_clr_o,
    output logic          mp_clr_o,
    output logic          sp_done_o,
    output logic          mp_done_o,
    output logic [DW-1:0] sp_rdata_o,
    output logic [DW-1:0] mp_rdata_o,
    output logic          booted_o
);
    localparam int CW = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(ACC_CYC - 1);

    typedef struct packed {
        arb_st_e       st;
        logic [CW-1:0] cnt;
        logic          sp_done;
        logic          mp_done;
        logic [DW-1:0] sp_rdata;
        logic [DW-1:0] mp_rdata;
        logic          booted;
    } core_t;

    core_t core_d, core_q;
    logic  last_w;

    always_comb begin
        core_d         = core_q;
        core_d.sp_done = 1'b0;
        core_d.mp_done = 1'b0;
        sp_clr_o       = 1'b0;
        mp_clr_o       = 1'b0;
        last_w         = (core_q.cnt == LAST);
        unique case (core_q.st)
            ST_IDLE: begin
                if (sp_pend_i && core_q.booted) begin
                    core_d.st  = ST_SP;
                    core_d.cnt = '0;
                end else if (sp_pend_i) begin
                    sp_clr_o        = 1'b1;
                    core_d.sp_done  = 1'b1;
                    core_d.sp_rdata = '0;
                end else if (mp_pend_i) begin
                    core_d.st  = ST_MP;
                    core_d.cnt = '0;
                end
            end
            ST_SP: begin
                if (last_w) begin
                    core_d.st      = ST_IDLE;
                    sp_clr_o       = 1'b1;
                    core_d.sp_done = 1'b1;
                    if (!sp_wr_i) core_d.sp_rdata = reg_rdata_i;
                end else begin
                    core_d.cnt = core_q.cnt + 1'b1;
                end
            end
            ST_MP: begin
                if (last_w) begin
                    core_d.st      = ST_IDLE;
                    mp_clr_o       = 1'b1;
                    core_d.mp_done = 1'b1;
                    if (!mp_wr_i) core_d.mp_rdata = reg_rdata_i;
                    if (mp_wr_i && mp_addr_i == BOOT_ADDR && mp_wdata_i[0])
                        core_d.booted = 1'b1;
                end else begin
                    core_d.cnt = core_q.cnt + 1'b1;
                end
            end
            default: core_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    always_comb begin
        reg_en_o    = (core_q.st != ST_IDLE);
        reg_addr_o  = (core_q.st == ST_SP) ? sp_addr_i  : mp_addr_i;
        reg_wdata_o = (core_q.st == ST_SP) ? sp_wdata_i : mp_wdata_i;
        reg_wr_o    = reg_en_o && ((core_q.st == ST_SP) ? sp_wr_i : mp_wr_i);
    end

    assign sp_done_o  = core_q.sp_done;
    assign mp_done_o  = core_q.mp_done;
    assign sp_rdata_o = core_q.sp_rdata;
    assign mp_rdata_o = core_q.mp_rdata;
    assign booted_o   = core_q.booted;

    // R2: the address stays put for the whole access window
    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en_o && core_q.cnt != LAST) |=> (reg_en_o && $stable(reg_addr_o)));
    // R3: with both pending at idle, the microprocessor is not granted next
    a_r3_serial_first: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_IDLE && sp_pend_i && mp_pend_i) |=> (core_q.st != ST_MP));
    // R6: a running microprocessor access is never cut short
    a_r6_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_MP && core_q.cnt != LAST) |=> (core_q.st == ST_MP));
    // R8: no serial grant before boot
    a_r8_boot_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_SP) |-> core_q.booted);
    // R9: the boot flag is sticky
    a_r9_boot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.booted |=> core_q.booted);
endmodule

// File: rtl/dhra_mp_hs.sv
module dhra_mp_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_ack_i,
    input  logic mp_pend_i,
    input  logic mp_done_i,
    output logic mp_rdy_o,
    output logic mp_dtack_n_o
);
    always_comb begin
        mp_rdy_o     = !(!mode_ack_i && mp_pend_i);
        mp_dtack_n_o = !(mode_ack_i && mp_done_i);
    end

    // R5: the acknowledge strobe lasts a single cycle
    a_r5_dtack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !mp_dtack_n_o |=> mp_dtack_n_o);
    // R4: in wait style the acknowledge strobe never fires
    a_r4_wait_no_dtack: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ack_i |-> mp_dtack_n_o);
endmodule

// File: rtl/dual_host_arb.sv
module dual_host_arb #(
    parameter int            AW        = 8,
    parameter int            DW        = 8,
    parameter int            ACC_CYC   = 3,
    parameter logic [AW-1:0] BOOT_ADDR = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mp_mode_ack,
    input  logic          mp_req,
    input  logic          mp_wr,
    input  logic [AW-1:0] mp_addr,
    input  logic [DW-1:0] mp_wdata,
    output logic          mp_rdy,
    output logic          mp_dtack_n,
    output logic [DW-1:0] mp_rdata,
    input  logic          sp_req,
    input  logic          sp_wr,
    input  logic [AW-1:0] sp_addr,
    input  logic [DW-1:0] sp_wdata,
    output logic          sp_done,
    output logic [DW-1:0] sp_rdata,
    output logic          boot_ok,
    output logic          reg_en,
    output logic          reg_wr,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata
);
    logic          sp_pend, sp_wr_l, sp_clr;
    logic [AW-1:0] sp_addr_l;
    logic [DW-1:0] sp_wdata_l;
    logic          mp_pend, mp_wr_l, mp_clr, mp_done;
    logic [AW-1:0] mp_addr_l;
    logic [DW-1:0] mp_wdata_l;

    dhra_req_latch #(.AW(AW), .DW(DW)) u_sp_lat (
        .clk(clk), .rst_n(rst_n), .req_i(sp_req), .wr_i(sp_wr),
        .addr_i(sp_addr), .wdata_i(sp_wdata), .clr_i(sp_clr),
        .pend_o(sp_pend), .wr_o(sp_wr_l), .addr_o(sp_addr_l), .wdata_o(sp_wdata_l)
    );

    dhra_req_latch #(.AW(AW), .DW(DW)) u_mp_lat (
        .clk(clk), .rst_n(rst_n), .req_i(mp_req), .wr_i(mp_wr),
        .addr_i(mp_addr), .wdata_i(mp_wdata), .clr_i(mp_clr),
        .pend_o(mp_pend), .wr_o(mp_wr_l), .addr_o(mp_addr_l), .wdata_o(mp_wdata_l)
    );

    dhra_arb_core #(.AW(AW), .DW(DW), .ACC_CYC(ACC_CYC), .BOOT_ADDR(BOOT_ADDR)) u_core (
        .clk(clk), .rst_n(rst_n),
        .sp_pend_i(sp_pend), .sp_wr_i(sp_wr_l), .sp_addr_i(sp_addr_l), .sp_wdata_i(sp_wdata_l),
        .mp_pend_i(mp_pend), .mp_wr_i(mp_wr_l), .mp_addr_i(mp_addr_l), .mp_wdata_i(mp_wdata_l),
        .reg_rdata_i(reg_rdata),
        .reg_en_o(reg_en), .reg_wr_o(reg_wr), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
        .sp_clr_o(sp_clr), .mp_clr_o(mp_clr), .sp_done_o(sp_done), .mp_done_o(mp_done),
        .sp_rdata_o(sp_rdata), .mp_rdata_o(mp_rdata), .booted_o(boot_ok)
    );

    dhra_mp_hs u_hs (
        .clk(clk), .rst_n(rst_n), .mode_ack_i(mp_mode_ack),
        .mp_pend_i(mp_pend), .mp_done_i(mp_done),
        .mp_rdy_o(mp_rdy), .mp_dtack_n_o(mp_dtack_n)
    );
endmodule

// File: tb/dual_host_arb_tb.sv
module dual_host_arb_tb;
    localparam int AW  = 8;
    localparam int DW  = 8;
    localparam int ACC = 3;
    localparam logic [AW-1:0] BADDR = 8'hFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mp_mode_ack = 1'b0, mp_req = 1'b0, mp_wr = 1'b0;
    logic [AW-1:0] mp_addr = '0;
    logic [DW-1:0] mp_wdata = '0;
    logic mp_rdy, mp_dtack_n, sp_done, boot_ok, reg_en, reg_wr;
    logic [DW-1:0] mp_rdata, sp_rdata, reg_wdata, reg_rdata;
    logic [AW-1:0] reg_addr;
    logic sp_req = 1'b0, sp_wr = 1'b0;
    logic [AW-1:0] sp_addr = '0;
    logic [DW-1:0] sp_wdata = '0;

    always #10 clk = ~clk;  // 50 MHz

    assign reg_rdata = reg_addr ^ 8'h5A;

    dual_host_arb #(.AW(AW), .DW(DW), .ACC_CYC(ACC), .BOOT_ADDR(BADDR)) u_dut (
        .clk(clk), .rst_n(rst_n), .mp_mode_ack(mp_mode_ack), .mp_req(mp_req),
        .mp_wr(mp_wr), .mp_addr(mp_addr), .mp_wdata(mp_wdata), .mp_rdy(mp_rdy),
        .mp_dtack_n(mp_dtack_n), .mp_rdata(mp_rdata), .sp_req(sp_req), .sp_wr(sp_wr),
        .sp_addr(sp_addr), .sp_wdata(sp_wdata), .sp_done(sp_done), .sp_rdata(sp_rdata),
        .boot_ok(boot_ok), .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int total = 0, bad = 0, cyc = 0;
    int rdy_low, dtack_cnt, en_cnt, sp_done_at, mp_done_at, cap_sp, cap_mp;
    int first_en_addr, bad_wr_cnt;
    logic prev_rdy = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mp_rdy) rdy_low++;
            if (mp_rdy && !prev_rdy) mp_done_at = cyc;
            if (!mp_dtack_n) begin dtack_cnt++; mp_done_at = cyc; end
            if (sp_done) sp_done_at = cyc;
            if (reg_en) begin
                if (first_en_addr < 0) first_en_addr = int'(reg_addr);
                en_cnt++;
            end
        end
        prev_rdy = mp_rdy;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        rdy_low = 0; dtack_cnt = 0; en_cnt = 0; sp_done_at = -1; mp_done_at = -1;
        first_en_addr = -1; bad_wr_cnt = 0; cap_sp = -1; cap_mp = -1;
    endtask

    // pulse requests at relative cycles; -1 means no pulse
    task automatic run(input int sp_at, input int mp_at, input int mp_at2);
        clr_mon();
        for (int i = 0; i <= 6; i++) begin
            @(negedge clk);
            sp_req = (i == sp_at);
            mp_req = (i == mp_at) || (i == mp_at2);
            if (i == sp_at) cap_sp = cyc + 1;
            if (i == mp_at) cap_mp = cyc + 1;
        end
        @(negedge clk);
        sp_req = 1'b0; mp_req = 1'b0;
        repeat (4 * ACC + 8) @(negedge clk);
    endtask

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic mp_mode_checks(input int lat);
        if (!mp_mode_ack) begin
            chk("R4 rdy low cycles", rdy_low, lat);
            chk("R4 no dtack", dtack_cnt, 0);
        end else begin
            chk("R5 rdy stays high", rdy_low, 0);
            chk("R5 one dtack", dtack_cnt, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdy", int'(mp_rdy), 1);
        chk("R1 dtack_n", int'(mp_dtack_n), 1);
        chk("R1 reg_en", int'(reg_en), 0);
        chk("R1 sp_done", int'(sp_done), 0);
        chk("R1 boot_ok", int'(boot_ok), 0);

        // R8 serial before boot
        sp_wr = 1'b0; sp_addr = 8'h03;
        run(0, -1, -1);
        chk("R8 reject latency", sp_done_at - cap_sp, 1);
        chk("R8 no access", en_cnt, 0);
        chk("R8 rdata zero", int'(sp_rdata), 0);

        // R2 R4 R5 R7: microprocessor sweep over modes, addresses and direction
        for (int m = 0; m < 2; m++) begin
            mp_mode_ack = m[0];
            for (int a = 0; a < 8; a++) begin
                for (int w = 0; w < 2; w++) begin
                    mp_addr = 8'(a * 17 + 1); mp_wr = w[0]; mp_wdata = 8'(a * 3 + 8'h40);
                    run(-1, 0, -1);
                    chk("R2 latency", mp_done_at - cap_mp, ACC + 1);
                    chk("R2 en cycles", en_cnt, ACC);
                    chk("R2 addr", first_en_addr, a * 17 + 1);
                    mp_mode_checks(ACC + 1);
                    if (!w[0]) chk("R7 mp rdata", int'(mp_rdata), (a * 17 + 1) ^ 8'h5A);
                end
            end
        end

        // R2 write strobe and data on the shared path
        mp_mode_ack = 1'b1; mp_wr = 1'b1; mp_addr = 8'h22; mp_wdata = 8'hC3;
        clr_mon();
        @(negedge clk); mp_req = 1'b1;
        @(negedge clk); mp_req = 1'b0;
        @(negedge clk);
        chk("R2 reg_wr", int'(reg_wr), 1);
        chk("R2 reg_wdata", int'(reg_wdata), 8'hC3);
        repeat (ACC + 4) @(negedge clk);

        // R9 boot flag
        mp_addr = BADDR; mp_wdata = 8'hFE;
        run(-1, 0, -1);
        chk("R9 bit0 clear no boot", int'(boot_ok), 0);
        mp_wdata = 8'h01;
        run(-1, 0, -1);
        chk("R9 boot set", int'(boot_ok), 1);
        mp_wdata = 8'h00;
        run(-1, 0, -1);
        chk("R9 boot sticky", int'(boot_ok), 1);

        // R2 R7 serial after boot
        sp_wr = 1'b0;
        for (int a = 0; a < 8; a++) begin
            sp_addr = 8'(a * 29 + 5);
            run(0, -1, -1);
            chk("R2 sp latency", sp_done_at - cap_sp, ACC + 1);
            chk("R2 sp en cycles", en_cnt, ACC);
            chk("R7 sp rdata", int'(sp_rdata), (a * 29 + 5) ^ 8'h5A);
        end

        // R3 serial first on collisions / near collisions
        sp_addr = 8'h10; mp_addr = 8'h20; mp_wr = 1'b0;
        for (int m = 0; m < 2; m++) begin
            mp_mode_ack = m[0];
            for (int k = 0; k <= ACC + 1; k++) begin
                run(0, k, -1);
                chk("R3 sp latency", sp_done_at - cap_sp, ACC + 1);
                chk("R3 mp latency", mp_done_at - cap_mp, maxi(ACC + 1, 2 * ACC + 2 - k));
                chk("R3 first addr", first_en_addr, 8'h10);
                chk("R3 en total", en_cnt, 2 * ACC);
                mp_mode_checks(maxi(ACC + 1, 2 * ACC + 2 - k));
                chk("R7 mp rdata", int'(mp_rdata), 8'h20 ^ 8'h5A);
            end
            // R6 microprocessor first, serial waits
            for (int k = 1; k <= ACC + 1; k++) begin
                run(k, 0, -1);
                chk("R6 mp latency", mp_done_at - cap_mp, ACC + 1);
                chk("R6 sp latency", sp_done_at - cap_sp, maxi(ACC + 1, 2 * ACC + 2 - k));
                chk("R6 first addr", first_en_addr, 8'h20);
                mp_mode_checks(ACC + 1);
            end
        end

        // R10 second pulse while pending ignored
        mp_mode_ack = 1'b1; mp_addr = 8'h31; mp_wr = 1'b0;
        run(-1, 0, 1);
        chk("R10 single access", en_cnt, ACC);
        chk("R10 single dtack", dtack_cnt, 1);
        chk("R10 rdata", int'(mp_rdata), 8'h31 ^ 8'h5A);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule